// File: doc/BRIEF.md
# Single-Line Character Scroll Engine

This block moves one character row sideways across a line, one pixel column at a time. The line is wider than the visible area. It is made of character cells of fixed pixel width, and the last cells of the line are hidden. Display fetch logic reads the block's pixel offset, and the leftmost visible character column, to work out which pixel of the line to show first.

Software programs the engine with a command byte that sets a direction and a speed. It then writes the number of the character row that should move. The speed is the number of frames per one-pixel shift; zero holds the line still. Every time the offset lands on a cell boundary, the engine raises a pulse toward the host. The pulse lasts a programmable number of clocks.

The position wraps around the whole line, hidden cells included, in both directions. The row that was scrolled stays locked: resuming motion after a stop accepts only that same row, until a reset command releases it.

Top module: `char_line_scroller`

## Requirements
- R1: After reset, the pixel offset and the leading column are 0, no row is moving, and the completion pulse is low.
- R2: The command byte holds the direction in bits 7:6 (00 reset, 01 move right, 10 move left, 11 pause) and the speed in bits 5:0. Any command write stops motion. After a move command, nothing moves until a row number is written.
- R3: When moving left at speed N (N from 1 to 63), the offset increases by exactly one on every Nth frame tick, counted from the row write.
- R4: When moving right at speed N, the offset decreases by exactly one on every Nth frame tick.
- R5: The offset wraps modulo 132 (22 cells of 6 pixels). Left from 131 gives 0, and right from 0 gives 131. The leading column equals offset divided by 6.
- R6: A speed of 0 leaves the offset unchanged, whatever frame ticks arrive.
- R7: A pause command stops motion. Row writes that follow a pause do not restart motion, and frame ticks leave the offset unchanged.
- R8: A reset command sets the offset and leading column to 0 and stops motion.
- R9: Once a row has been scrolled, a row write with a different number is ignored: no motion, and the reported row is unchanged. The same number restarts motion. After a reset command, any row number is accepted.
- R10: Each step that lands the offset on a multiple of 6 raises the completion pulse for exactly PULSE_CLKS clocks. Steps that land elsewhere do not raise it.
- R11: The engine reports the accepted row number, and an active flag that is high only while motion is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-clock pulse per display frame |
| cmd_wr | input | 1 | Strobe for the command byte |
| cmd_data | input | 8 | Direction (7:6) and speed (5:0) |
| row_wr | input | 1 | Strobe for the row number |
| row_data | input | 3 | Character row to scroll |
| pix_offset | output | 8 | Leftmost visible pixel column of the line |
| lead_col | output | 5 | Leftmost visible character column |
| scroll_row | output | 3 | Accepted row number |
| row_active | output | 1 | Motion enabled |
| cell_done | output | 1 | Completion pulse toward the host |

## Verification
The offset is driven at speeds 1, 2 and 3 in both directions. Step counts at these speeds separate an off-by-one frame divider from a correct one, and show left and right applied the right way round. Runs that start at offset 0 in each direction cover the wrap through the hidden cells, and they reveal a wrong wrap point or a wrong boundary test for the pulse. Speed zero, pause, a row write with a wrong number and a reset command each tell a stopped line apart from one that still creeps. The pulse is measured clock by clock to pin down its width.

// File: rtl/char_line_scroller.sv
module char_line_scroller #(
  parameter int CHAR_COLS  = 22,
  parameter int CELL_PX    = 6,
  parameter int ROW_W      = 3,
  parameter int SPEED_W    = 6,
  parameter int PULSE_CLKS = 2000
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               frame_tick,
  input  logic                               cmd_wr,
  input  logic [SPEED_W+1:0]                 cmd_data,
  input  logic                               row_wr,
  input  logic [ROW_W-1:0]                   row_data,
  output logic [$clog2(CHAR_COLS*CELL_PX)-1:0] pix_offset,
  output logic [$clog2(CHAR_COLS)-1:0]       lead_col,
  output logic [ROW_W-1:0]                   scroll_row,
  output logic                               row_active,
  output logic                               cell_done
);
  localparam int LINE_PX = CHAR_COLS * CELL_PX;
  localparam int OFF_W   = $clog2(LINE_PX);
  localparam int COL_W   = $clog2(CHAR_COLS);
  localparam int SUB_W   = $clog2(CELL_PX);
  localparam int PC_W    = $clog2(PULSE_CLKS + 1);
  localparam logic [1:0] D_RST = 2'b00, D_RIGHT = 2'b01, D_LEFT = 2'b10;

  logic [1:0]         dir_q;
  logic [SPEED_W-1:0] speed_q, fcnt_q;
  logic [COL_W-1:0]   col_q;
  logic [SUB_W-1:0]   sub_q;
  logic [ROW_W-1:0]   row_q;
  logic               locked_q, wait_q, run_q;
  logic [PC_W-1:0]    pulse_q;

  wire [1:0]       cmd_dir = cmd_data[SPEED_W+1:SPEED_W];
  wire [SPEED_W:0] fnext   = {1'b0, fcnt_q} + 1'b1;
  wire go_left  = (dir_q == D_LEFT);
  wire tick_ok  = !cmd_wr && run_q && frame_tick && (speed_q != '0);
  wire step     = tick_ok && (fnext >= {1'b0, speed_q});
  wire row_ok   = !cmd_wr && row_wr && wait_q && (!locked_q || row_data == row_q);
  wire landing  = go_left ? (sub_q == SUB_W'(CELL_PX - 1)) : (sub_q == SUB_W'(1));

  assign pix_offset = OFF_W'(col_q) * OFF_W'(CELL_PX) + OFF_W'(sub_q);
  assign lead_col   = col_q;
  assign scroll_row = row_q;
  assign row_active = run_q;
  assign cell_done  = (pulse_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= D_RST; speed_q <= '0; fcnt_q <= '0;
      col_q <= '0; sub_q <= '0; row_q <= '0;
      locked_q <= 1'b0; wait_q <= 1'b0; run_q <= 1'b0;
    end else if (cmd_wr) begin
      dir_q   <= cmd_dir;
      speed_q <= cmd_data[SPEED_W-1:0];
      fcnt_q  <= '0;
      run_q   <= 1'b0;
      wait_q  <= (cmd_dir == D_LEFT) || (cmd_dir == D_RIGHT);
      if (cmd_dir == D_RST) begin
        col_q <= '0; sub_q <= '0; locked_q <= 1'b0;
      end
    end else if (row_ok) begin
      row_q <= row_data; locked_q <= 1'b1;
      run_q <= 1'b1; wait_q <= 1'b0; fcnt_q <= '0;
    end else if (tick_ok) begin
      if (step) begin
        fcnt_q <= '0;
        if (go_left) begin
          if (sub_q == SUB_W'(CELL_PX - 1)) begin
            sub_q <= '0;
            col_q <= (col_q == COL_W'(CHAR_COLS - 1)) ? '0 : col_q + 1'b1;
          end else sub_q <= sub_q + 1'b1;
        end else begin
          if (sub_q == '0) begin
            sub_q <= SUB_W'(CELL_PX - 1);
            col_q <= (col_q == '0) ? COL_W'(CHAR_COLS - 1) : col_q - 1'b1;
          end else sub_q <= sub_q - 1'b1;
        end
      end else fcnt_q <= fnext[SPEED_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                pulse_q <= '0;
    else if (step && landing)  pulse_q <= PC_W'(PULSE_CLKS);
    else if (pulse_q != '0)    pulse_q <= pulse_q - 1'b1;
  end

  a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pix_offset < OFF_W'(LINE_PX));
  a_r6_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_tick && !(cmd_wr && cmd_dir == D_RST)) |=> $stable(pix_offset));
  a_r8_reset_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_dir == D_RST) |=> (pix_offset == '0) && !row_active);
  a_r2_cmd_stops: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> !row_active);
  a_r9_row_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (row_wr && !cmd_wr && locked_q && row_data != scroll_row) |=> $stable(scroll_row));
  a_r10_pulse_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cell_done) |-> (pix_offset % OFF_W'(CELL_PX) == '0));
endmodule

// File: tb/test_char_line_scroller.sv
`timescale 1ns/1ps
module test_char_line_scroller;
  localparam int PW = 5;
  logic clk = 0, rst_n = 0, frame_tick = 0, cmd_wr = 0, row_wr = 0;
  logic [7:0] cmd_data = 0;
  logic [2:0] row_data = 0;
  logic [7:0] pix_offset;
  logic [4:0] lead_col;
  logic [2:0] scroll_row;
  logic row_active, cell_done;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  char_line_scroller #(.PULSE_CLKS(PW)) i_char_line_scroller (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .cmd_wr(cmd_wr),
    .cmd_data(cmd_data), .row_wr(row_wr), .row_data(row_data),
    .pix_offset(pix_offset), .lead_col(lead_col), .scroll_row(scroll_row),
    .row_active(row_active), .cell_done(cell_done));

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) frame_tick = 1;
      @(negedge clk) frame_tick = 0;
    end
  endtask

  task automatic wr_cmd(logic [1:0] d, logic [5:0] s);
    @(negedge clk) begin cmd_wr = 1; cmd_data = {d, s}; end
    @(negedge clk) cmd_wr = 0;
  endtask

  task automatic wr_row(logic [2:0] r);
    @(negedge clk) begin row_wr = 1; row_data = r; end
    @(negedge clk) row_wr = 0;
  endtask

  task automatic t_power_on;
    check("R1 offset", pix_offset, 0);
    check("R1 lead_col", lead_col, 0);
    check("R1 active", row_active, 0);
    check("R1 cell_done", cell_done, 0);
  endtask

  task automatic t_arm_wait;
    wr_cmd(2'b10, 6'd3);
    tick(3);
    check("R2 no move before row", pix_offset, 0);
    check("R2 inactive before row", row_active, 0);
    wr_row(3'd2);
    check("R11 active", row_active, 1);
    check("R11 row", scroll_row, 2);
  endtask

  task automatic t_left_rate;
    tick(2);
    check("R3 two of three ticks", pix_offset, 0);
    tick(1);
    check("R3 third tick", pix_offset, 1);
    tick(2);
    check("R3 fifth tick", pix_offset, 1);
    tick(1);
    check("R3 sixth tick", pix_offset, 2);
  endtask

  task automatic t_cell_pulse;
    wr_cmd(2'b10, 6'd1);
    wr_row(3'd2);
    tick(3);
    check("R10 no pulse at 5", cell_done, 0);
    check("R3 speed one", pix_offset, 5);
    tick(1);
    check("R5 lead col", lead_col, 1);
    check("R10 pulse start", cell_done, 1);
    for (int i = 0; i < PW - 1; i++) begin
      @(negedge clk);
      check("R10 pulse held", cell_done, 1);
    end
    @(negedge clk);
    check("R10 pulse end", cell_done, 0);
  endtask

  task automatic t_right_rate;
    wr_cmd(2'b01, 6'd2);
    wr_row(3'd2);
    tick(1);
    check("R4 first of two", pix_offset, 6);
    tick(3);
    check("R4 four ticks", pix_offset, 4);
  endtask

  task automatic t_speed_zero;
    wr_cmd(2'b10, 6'd0);
    wr_row(3'd2);
    tick(4);
    check("R6 speed zero", pix_offset, 4);
  endtask

  task automatic t_pause;
    wr_cmd(2'b11, 6'd1);
    wr_row(3'd2);
    check("R7 inactive", row_active, 0);
    tick(3);
    check("R7 held", pix_offset, 4);
  endtask

  task automatic t_row_lock;
    wr_cmd(2'b10, 6'd1);
    wr_row(3'd5);
    check("R9 other row ignored", row_active, 0);
    check("R9 row kept", scroll_row, 2);
    tick(1);
    check("R9 no move", pix_offset, 4);
    wr_row(3'd2);
    tick(1);
    check("R9 same row resumes", pix_offset, 5);
  endtask

  task automatic t_reset_cmd;
    wr_cmd(2'b00, 6'd5);
    check("R8 offset", pix_offset, 0);
    check("R8 lead col", lead_col, 0);
    check("R8 stopped", row_active, 0);
    tick(2);
    check("R8 stays", pix_offset, 0);
  endtask

  task automatic t_wrap;
    repeat (PW + 1) @(negedge clk);
    wr_cmd(2'b01, 6'd1);
    wr_row(3'd5);
    check("R9 new row after reset", scroll_row, 5);
    tick(1);
    check("R5 right wrap", pix_offset, 131);
    check("R5 wrap col", lead_col, 21);
    check("R10 no pulse at 131", cell_done, 0);
    wr_cmd(2'b10, 6'd1);
    wr_row(3'd5);
    tick(1);
    check("R5 left wrap", pix_offset, 0);
    check("R10 pulse at wrap", cell_done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_power_on();
    t_arm_wait();
    t_left_rate();
    t_cell_pulse();
    t_right_rate();
    t_speed_zero();
    t_pause();
    t_row_lock();
    t_reset_cmd();
    t_wrap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog R1..all actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule